// File: doc/BRIEF.md
# Synchronous Charge-Balance Pulse Modulator

This block is a digital model of a synchronous voltage-to-frequency modulator. A signed 16-bit code stands for an analog input measured against a reference full scale of 16384. Each system clock, a first-order charge-balance loop adds a contribution derived from the input to an accumulator. It then compares the result against a fixed reference quantum. When the quantum is reached, the loop subtracts it and issues an output pulse one clock wide.

The long-run pulse rate is 0.1·fclk + 0.8·(code/16384)·fclk. A zero code therefore gives a tenth of the clock rate and a full-scale code gives nine tenths. Codes up to 6% of full scale outside the nominal span on either side are honoured, and anything beyond that is clamped. A downstream counter that gates the pulse train with a window derived from the same clock gets a result that is independent of the absolute clock frequency. When the enable input is low, the loop is frozen and the output rests high, which is the idle level.

Top module: `cb_pulse_mod`

## Requirements
- R1: Before it enters the loop, the input code is clamped to the range -983 to 17367, which is 6% of full scale beyond each end. A code outside that range behaves exactly like the nearest limit.
- R2: Reset is synchronous and active high. While it is sampled high, the accumulator is set to the mid value 81920 and the output goes low on the following cycle.
- R3: On each clock with enable high and reset low, the loop forms s = acc + 16384 + 8·xc, where xc is the clamped code. If s ≥ 163840, the output is high in the next cycle and acc becomes s − 163840. Otherwise the output is low and acc becomes s.
- R4: With zero input, the output carries 100±1 pulses per 1000 clocks. With full-scale input (16384), it carries 900±1 pulses per 1000 clocks.
- R5: At the overrange limits, the rate is 52±1 pulses per 1000 clocks (code -983) and 948±1 pulses per 1000 clocks (code 17367). Codes of -20000 and 32767 give the same counts.
- R6: With code 4096, which gives an average of 3/10 of the clock rate, every interval between successive pulses is 3 or 4 clocks.
- R7: While enable is low, the output is high on every following cycle and the accumulator keeps its value. When enable returns high, the pulse sequence continues from the held state.
- R8: After a step from zero input to full scale, a window that starts two clocks after the step holds 90±1 pulses per 100 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sets the full-scale rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; low freezes the loop and idles the output high |
| code | input | 16 | Signed input code; full scale is 16384 |
| pulse_o | output | 1 | Output pulse train, one clock per pulse |

## Verification
The assertions assume that reset is applied for at least one clock before any enabled operation. They also assume that enable and code are steady around the rising edge, with no other constraint on their values. The stimulus changes the inputs only on falling edges, and it holds reset high for several clocks at the start. Its code values include ones far outside the clamp range, so that the clamp path is covered alongside the nominal and overrange values.

// File: rtl/cb_pulse_mod.sv
module cb_pulse_mod #(
  parameter int IN_W    = 16,
  parameter int FS_LOG2 = 14,
  parameter int OVR_PCT = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [IN_W-1:0] code,
  output logic                   pulse_o
);
  localparam int FS    = 1 << FS_LOG2;
  localparam int QUANT = 10 * FS;
  localparam int OVR   = (FS * OVR_PCT) / 100;
  localparam int LO    = -OVR;
  localparam int HI    = FS + OVR;
  localparam int MID   = QUANT / 2;
  localparam int AW    = $clog2(QUANT) + 1;

  logic signed [IN_W-1:0] xc;
  logic [AW-1:0] acc, inc, sum;
  logic hit;

  assign xc  = (int'(code) < LO) ? IN_W'(LO) :
               (int'(code) > HI) ? IN_W'(HI) : code;
  assign inc = AW'(FS + 8 * int'(xc));
  assign sum = acc + inc;
  assign hit = sum >= AW'(QUANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= AW'(MID);
      pulse_o <= 1'b0;
    end else if (!en) begin
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= hit;
      acc     <= hit ? sum - AW'(QUANT) : sum;
    end
  end

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_r2_reset_state: assert (acc == AW'(MID) && !pulse_o)
        else $error("reset state wrong");
    end
  end

  a_r3_acc_range: assert property (@(posedge clk) disable iff (rst)
    acc < AW'(QUANT));

  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    !en |=> pulse_o);

  a_r7_hold_state: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
endmodule

// File: tb/cb_pulse_mod_bench.sv
module cb_pulse_mod_bench;
  localparam int Q = 163840;
  localparam int MID = 81920;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic signed [15:0] code = '0;
  logic pulse_o;

  always #5 clk = ~clk;

  cb_pulse_mod u_cb_pulse_mod (.clk(clk), .rst(rst), .en(en), .code(code), .pulse_o(pulse_o));

  int checks = 0, errors = 0;
  int macc = MID;
  bit exp_q[$];
  string tag = "R2";
  int npulse = 0, cyc = 0, last_p = -1, gaps = 0, bad_gaps = 0;
  bit r6_on = 0;
  bit done = 0;

  function automatic int clampv(int x);
    if (x < -983) return -983;
    if (x > 17367) return 17367;
    return x;
  endfunction

  task automatic drive(input int x, input bit e, input bit r);
    int s;
    bit ex;
    @(negedge clk);
    code = 16'(x); en = e; rst = r;
    if (r) begin macc = MID; ex = 0; end
    else if (!e) ex = 1;
    else begin
      s = macc + 16384 + 8 * clampv(x);
      if (s >= Q) begin ex = 1; macc = s - Q; end
      else begin ex = 0; macc = s; end
    end
    exp_q.push_back(ex);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      checks++;
      if (pulse_o !== e) begin
        errors++;
        $display("FAIL %s scoreboard cycle %0d: actual=%b expected=%b", tag, cyc, pulse_o, e);
      end
      if (pulse_o === 1'b1) begin
        npulse++;
        if (r6_on && last_p >= 0) begin
          gaps++;
          if (cyc - last_p != 3 && cyc - last_p != 4) bad_gaps++;
        end
        last_p = cyc;
      end
      cyc++;
    end
  end

  task automatic check_range(input string t, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", t, act, lo, hi);
    end
  endtask

  task automatic window(input string t, input int x, input int n, input int lo, input int hi);
    int c0;
    tag = t;
    c0 = npulse;
    repeat (n) drive(x, 1, 0);
    @(posedge clk); #2;
    check_range(t, npulse - c0, lo, hi);
  endtask

  initial begin
    int c0;
    repeat (4) drive(0, 1, 1);
    tag = "R3";
    repeat (40) drive(0, 1, 0);
    window("R4 zero", 0, 1000, 99, 101);
    window("R4 full", 16384, 1000, 899, 901);
    window("R5 low limit", -983, 1000, 51, 53);
    window("R5 high limit", 17367, 1000, 947, 949);
    window("R1 clamp low", -20000, 1000, 51, 53);
    window("R1 clamp high", 32767, 1000, 947, 949);
    tag = "R3";
    for (int i = 0; i < 300; i++) drive((i * 977) % 18000 - 500, 1, 0);
    tag = "R7";
    @(posedge clk); #2;
    c0 = npulse;
    repeat (8) drive(3000, 0, 0);
    @(posedge clk); #2;
    check_range("R7 idle high", npulse - c0, 8, 8);
    tag = "R7 resume";
    repeat (50) drive(3000, 1, 0);
    tag = "R2";
    repeat (2) drive(5000, 1, 1);
    repeat (30) drive(5000, 1, 0);
    tag = "R6";
    last_p = -1; r6_on = 1;
    repeat (600) drive(4096, 1, 0);
    @(posedge clk); #2;
    r6_on = 0;
    checks++;
    if (bad_gaps != 0 || gaps < 100) begin
      errors++;
      $display("FAIL R6 intervals: actual bad=%0d of %0d expected bad=0", bad_gaps, gaps);
    end
    window("R8 before step", 0, 200, 19, 21);
    tag = "R8";
    repeat (2) drive(16384, 1, 0);
    window("R8 settled", 16384, 100, 89, 91);
    @(posedge clk); #2;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 queue: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule